// File: doc/BRIEF.md
# Ethernet MAC Link Flow Control Unit

This unit sits beside the transmit and receive paths of an Ethernet MAC and handles link-level flow control. Software owns three control bits and a pause-time value: one bit lets received Pause frames stall the local transmitter, one bit permits this station to throttle its link partner, and a third bit has two meanings. In full duplex that third bit is a one-shot request to emit a Pause control frame; it stays set while that frame goes out and hardware clears it afterwards. In half duplex the same bit is a level-held back-pressure request. While it is held, every frame that starts arriving makes the unit ask the transmit path for a 32-bit jam, so the sender sees a collision and backs off.

On the receive side a byte parser recognises MAC control Pause frames. It loads a down-counter with the pause time they carry, counted in quanta of 512 bit times. A tick input marks each quantum. While the counter is non-zero the unit holds the transmitter off. The outgoing control frame is offered byte by byte on a valid/ready stream, without CRC. A downstream stage appends the CRC.

Top module: `mac_pause_ctrl`

## Requirements
- R1: After synchronous reset, all three readback bits are 0. `tx_hold`, `jam_strobe` and `ctl_valid` are also 0.
- R2: When no control frame is pending or in flight, a `cfg_we` pulse loads the receive-enable, transmit-enable and pause-time values. The new bits show on the readback ports on the next cycle.
- R3: In full duplex, a write with `cfg_kick`=1 and `cfg_tx_fc_en`=1 starts a control frame of FRAME_BYTES (default 60) bytes on the `ctl_*` stream. The bytes are, in order:
  - bytes 0-5: 01 80 C2 00 00 01
  - bytes 6-11: STATION_ADDR, most significant byte first
  - bytes 12-13: 88 08
  - bytes 14-15: 00 01
  - bytes 16-17: the written pause time, high byte first
  - remaining bytes: zero

  `ctl_last` marks the final byte. The stream advances only on a cycle with `ctl_valid` and `ctl_ready` both high. While it is stalled, data and last stay unchanged.
- R4: In full duplex, `st_kick` reads 1 from the cycle after the requesting write until the final byte is accepted. It reads 0 on the following cycle.
- R5: In full duplex, while `st_kick` is 1, any `cfg_we` is ignored and the readback bits do not change.
- R6: In full duplex, a write with `cfg_kick`=1 but `cfg_tx_fc_en`=0 leaves `st_kick` at 0 and emits no frame.
- R7: With receive enable set, a recognised Pause frame raises `tx_hold` two cycles after its final byte is sampled. With receive enable clear, Pause frames are ignored. Clearing the enable also drops any running hold within two cycles.
- R8: Each `quanta_tick` decrements the pause count, and `tx_hold` falls when the count reaches zero. A new Pause frame reloads the count. A pause time of 0 releases the hold at once.
- R9: A frame is recognised only if all of the following hold:
  - its first byte is marked by `rx_sof`;
  - bytes 0-5 are 01 80 C2 00 00 01;
  - bytes 12-13 are 88 08;
  - bytes 14-15 are 00 01;
  - it is at least 18 bytes long.

  Any other frame leaves `tx_hold` unchanged.
- R10: In half duplex, `st_kick` holds the written value. With both `st_kick` and `st_tx_fc_en` at 1, each received byte with `rx_valid` and `rx_sof` high produces a one-cycle `jam_strobe` on the following cycle. That strobe requests a 32-bit jam. No control frame is emitted in half duplex.
- R11: When `full_duplex` goes from 0 to 1, `st_kick` clears. No `jam_strobe` occurs in full duplex. After returning to half duplex, back pressure stays off until software sets the bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| cfg_we | input | 1 | Write strobe for the control values |
| cfg_rx_fc_en | input | 1 | Write value: obey received Pause frames |
| cfg_tx_fc_en | input | 1 | Write value: allow Pause frames / back pressure |
| cfg_kick | input | 1 | Write value: send-Pause request / back-pressure level |
| cfg_tx_quanta | input | 16 | Write value: pause time placed in sent frames |
| st_rx_fc_en | output | 1 | Readback of receive enable |
| st_tx_fc_en | output | 1 | Readback of transmit enable |
| st_kick | output | 1 | Readback of busy / back-pressure bit |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| quanta_tick | input | 1 | One pulse per 512 bit times |
| tx_hold | output | 1 | Transmitter must not start frames |
| jam_strobe | output | 1 | One-cycle request for a 32-bit jam |
| ctl_valid | output | 1 | Control frame byte valid |
| ctl_data | output | 8 | Control frame byte |
| ctl_last | output | 1 | Final control frame byte |
| ctl_ready | input | 1 | Transmit path accepts the byte |

## Verification
The bench stalls the outgoing control frame with an irregular ready pattern. A design that advanced without a handshake would drop or repeat header bytes. One that cleared the busy bit early would lose the count of 60. It also tries a write in the middle of the frame: an unlocked register would take the zeroed enables. On receive it sends frames that are wrong in only the destination, type or opcode, or that are one byte short. A loose matcher would raise the hold on one of them. It also sends a reload with a smaller pause time and a zero pause time, which expose a timer that only adds or never releases. Finally it flips duplex with back pressure held. A design that kept the bit across the switch would jam in full duplex or resume jamming on the return to half duplex.

// File: rtl/mpc_pkg.sv
package mpc_pkg;

    localparam int QW        = 16;
    localparam int RX_IDX_W  = 5;
    localparam int HDR_BYTES = 18;

    localparam logic [47:0] PAUSE_DA  = 48'h0180C2000001;
    localparam logic [15:0] CTL_ETYPE = 16'h8808;
    localparam logic [15:0] OPC_PAUSE = 16'h0001;

    typedef struct packed {
        logic          rx_en;
        logic          tx_en;
        logic          kick;
        logic [QW-1:0] quanta;
    } fc_cfg_t;

    typedef struct packed {
        logic          hit;
        logic [QW-1:0] quanta;
    } pause_evt_t;

    // Byte i (0 = most significant) of a 48-bit station address.
    function automatic logic [7:0] addr_byte(input logic [47:0] a, input int unsigned i);
        logic [47:0] s;
        s = (i < 6) ? (a >> (40 - 8 * i)) : 48'd0;
        return s[7:0];
    endfunction

    // True when byte i of a received frame is consistent with a Pause frame.
    function automatic logic hdr_byte_ok(input int unsigned i, input logic [7:0] d);
        logic ok;
        ok = 1'b1;
        if (i < 6)        ok = (d == addr_byte(PAUSE_DA, i));
        else if (i == 12) ok = (d == CTL_ETYPE[15:8]);
        else if (i == 13) ok = (d == CTL_ETYPE[7:0]);
        else if (i == 14) ok = (d == OPC_PAUSE[15:8]);
        else if (i == 15) ok = (d == OPC_PAUSE[7:0]);
        return ok;
    endfunction

    // Byte i of the outgoing Pause control frame.
    function automatic logic [7:0] ctl_byte(input int unsigned i, input logic [47:0] sa,
                                            input logic [QW-1:0] q);
        logic [7:0] b;
        b = 8'h00;
        if (i < 6)        b = addr_byte(PAUSE_DA, i);
        else if (i < 12)  b = addr_byte(sa, i - 6);
        else if (i == 12) b = CTL_ETYPE[15:8];
        else if (i == 13) b = CTL_ETYPE[7:0];
        else if (i == 14) b = OPC_PAUSE[15:8];
        else if (i == 15) b = OPC_PAUSE[7:0];
        else if (i == 16) b = q[15:8];
        else if (i == 17) b = q[7:0];
        return b;
    endfunction

endpackage

// File: rtl/mpc_cfg_regs.sv
module mpc_cfg_regs
    import mpc_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    full_duplex,
    input  logic    wr_en,
    input  fc_cfg_t wr,
    input  logic    frame_busy,
    input  logic    frame_done,
    output fc_cfg_t cfg,
    output logic    start
);

    fc_cfg_t cfg_q;
    logic    fd_q;
    logic    reject;
    logic    accept;
    logic    fd_rise;

    assign reject  = (full_duplex & cfg_q.kick) | frame_busy;
    assign accept  = wr_en & ~reject;
    assign fd_rise = full_duplex & ~fd_q;
    assign start   = accept & full_duplex & wr.kick & wr.tx_en;
    assign cfg     = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            fd_q  <= 1'b0;
        end else begin
            fd_q <= full_duplex;
            if (accept) begin
                cfg_q.rx_en  <= wr.rx_en;
                cfg_q.tx_en  <= wr.tx_en;
                cfg_q.quanta <= wr.quanta;
            end
            if (frame_done)
                cfg_q.kick <= 1'b0;
            else if (accept)
                cfg_q.kick <= full_duplex ? (wr.kick & wr.tx_en) : wr.kick;
            else if (fd_rise && !frame_busy)
                cfg_q.kick <= 1'b0;
        end
    end

    // R5: register locked while a full-duplex request is pending
    a_r5_locked_while_busy: assert property (@(posedge clk) disable iff (rst)
        (full_duplex && cfg_q.kick) |=> ($stable(cfg_q.rx_en) && $stable(cfg_q.tx_en)
                                         && $stable(cfg_q.quanta)));

    // R6: no full-duplex request without transmit enable
    a_r6_kick_needs_tx: assert property (@(posedge clk) disable iff (rst)
        (full_duplex && wr_en && !reject && !wr.tx_en) |=> !cfg_q.kick);

    // R4: completion clears the busy bit
    a_r4_done_clears: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> !cfg_q.kick);

endmodule

// File: rtl/mpc_ctl_tx.sv
module mpc_ctl_tx
    import mpc_pkg::*;
#(
    parameter int          FRAME_BYTES  = 60,
    parameter logic [47:0] STATION_ADDR = 48'h021A2B3C4D5E
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [QW-1:0] quanta,
    input  logic          ctl_ready,
    output logic          ctl_valid,
    output logic [7:0]    ctl_data,
    output logic          ctl_last,
    output logic          busy,
    output logic          done
);

    localparam int IDX_W = $clog2(FRAME_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BYTES - 1);

    logic             sending_q;
    logic [IDX_W-1:0] idx_q;
    logic [QW-1:0]    q_snap;

    assign ctl_valid = sending_q;
    assign ctl_last  = sending_q & (idx_q == LAST_IDX);
    assign ctl_data  = ctl_byte(32'(idx_q), STATION_ADDR, q_snap);
    assign busy      = sending_q;
    assign done      = sending_q & ctl_ready & (idx_q == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            sending_q <= 1'b0;
            idx_q     <= '0;
            q_snap    <= '0;
        end else if (start && !sending_q) begin
            sending_q <= 1'b1;
            idx_q     <= '0;
            q_snap    <= quanta;
        end else if (sending_q && ctl_ready) begin
            if (idx_q == LAST_IDX) begin
                sending_q <= 1'b0;
                idx_q     <= '0;
            end else begin
                idx_q <= idx_q + IDX_W'(1);
            end
        end
    end

    // R3: a stalled byte is held unchanged
    a_r3_stall_holds: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && !ctl_ready) |=> (ctl_valid && $stable(ctl_data) && $stable(ctl_last)));

    // R3: a new frame never starts over one in flight
    a_r3_no_restart: assert property (@(posedge clk) disable iff (rst)
        start |-> !sending_q);

endmodule

// File: rtl/mpc_rx_pause.sv
module mpc_rx_pause
    import mpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_sof,
    input  logic       rx_eof,
    output pause_evt_t evt
);

    localparam logic [RX_IDX_W-1:0] IDX_MAX = '1;

    logic [RX_IDX_W-1:0] idx_q;
    logic [RX_IDX_W-1:0] cur_idx;
    logic                match_q;
    logic                match_nxt;
    logic                byte_ok;
    logic [7:0]          qh_q;
    logic [7:0]          ql_q;
    logic                hit_q;

    assign cur_idx   = rx_sof ? '0 : idx_q;
    assign byte_ok   = hdr_byte_ok(32'(cur_idx), rx_data);
    assign match_nxt = rx_sof ? byte_ok : (match_q & byte_ok);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q   <= '0;
            match_q <= 1'b0;
            qh_q    <= '0;
            ql_q    <= '0;
            hit_q   <= 1'b0;
        end else begin
            hit_q <= 1'b0;
            if (rx_valid) begin
                idx_q   <= (cur_idx == IDX_MAX) ? IDX_MAX : cur_idx + RX_IDX_W'(1);
                match_q <= match_nxt;
                if (cur_idx == RX_IDX_W'(16)) qh_q <= rx_data;
                if (cur_idx == RX_IDX_W'(17)) ql_q <= rx_data;
                if (rx_eof)
                    hit_q <= match_nxt && (cur_idx >= RX_IDX_W'(HDR_BYTES - 1));
            end
        end
    end

    assign evt.hit    = hit_q;
    assign evt.quanta = {qh_q, ql_q};

    // R9: a decode event only follows the end of a frame
    a_r9_hit_after_eof: assert property (@(posedge clk) disable iff (rst)
        evt.hit |-> $past(rx_valid && rx_eof));

endmodule

// File: rtl/mpc_pause_timer.sv
module mpc_pause_timer
    import mpc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rx_en,
    input  pause_evt_t evt,
    input  logic       tick,
    output logic       hold
);

    logic [QW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !rx_en)
            cnt_q <= '0;
        else if (evt.hit)
            cnt_q <= evt.quanta;
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - QW'(1);
    end

    assign hold = (cnt_q != '0);

    // R8: the hold only starts from a decoded frame
    a_r8_rise_from_frame: assert property (@(posedge clk) disable iff (rst)
        $rose(hold) |-> $past(evt.hit));

    // R7: disabling reception releases the transmitter
    a_r7_disable_releases: assert property (@(posedge clk) disable iff (rst)
        !rx_en |=> !hold);

endmodule

// File: rtl/mac_pause_ctrl.sv
module mac_pause_ctrl
    import mpc_pkg::*;
#(
    parameter int          FRAME_BYTES  = 60,
    parameter logic [47:0] STATION_ADDR = 48'h021A2B3C4D5E
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        full_duplex,
    input  logic        cfg_we,
    input  logic        cfg_rx_fc_en,
    input  logic        cfg_tx_fc_en,
    input  logic        cfg_kick,
    input  logic [15:0] cfg_tx_quanta,
    output logic        st_rx_fc_en,
    output logic        st_tx_fc_en,
    output logic        st_kick,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    input  logic        rx_sof,
    input  logic        rx_eof,
    input  logic        quanta_tick,
    output logic        tx_hold,
    output logic        jam_strobe,
    output logic        ctl_valid,
    output logic [7:0]  ctl_data,
    output logic        ctl_last,
    input  logic        ctl_ready
);

    fc_cfg_t    wr_cfg;
    fc_cfg_t    cfg;
    pause_evt_t evt;
    logic       start;
    logic       frame_busy;
    logic       frame_done;
    logic       jam_q;

    always_comb begin
        wr_cfg.rx_en  = cfg_rx_fc_en;
        wr_cfg.tx_en  = cfg_tx_fc_en;
        wr_cfg.kick   = cfg_kick;
        wr_cfg.quanta = cfg_tx_quanta;
    end

    mpc_cfg_regs u_cfg (
        .clk        (clk),
        .rst        (rst),
        .full_duplex(full_duplex),
        .wr_en      (cfg_we),
        .wr         (wr_cfg),
        .frame_busy (frame_busy),
        .frame_done (frame_done),
        .cfg        (cfg),
        .start      (start)
    );

    mpc_ctl_tx #(
        .FRAME_BYTES (FRAME_BYTES),
        .STATION_ADDR(STATION_ADDR)
    ) u_ctl_tx (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .quanta   (cfg_tx_quanta),
        .ctl_ready(ctl_ready),
        .ctl_valid(ctl_valid),
        .ctl_data (ctl_data),
        .ctl_last (ctl_last),
        .busy     (frame_busy),
        .done     (frame_done)
    );

    mpc_rx_pause u_rx (
        .clk     (clk),
        .rst     (rst),
        .rx_valid(rx_valid),
        .rx_data (rx_data),
        .rx_sof  (rx_sof),
        .rx_eof  (rx_eof),
        .evt     (evt)
    );

    mpc_pause_timer u_timer (
        .clk  (clk),
        .rst  (rst),
        .rx_en(cfg.rx_en),
        .evt  (evt),
        .tick (quanta_tick),
        .hold (tx_hold)
    );

    // Half-duplex back pressure: one jam request per arriving frame.
    always_ff @(posedge clk) begin
        if (rst)
            jam_q <= 1'b0;
        else
            jam_q <= ~full_duplex & cfg.kick & cfg.tx_en & rx_valid & rx_sof;
    end

    assign jam_strobe  = jam_q;
    assign st_rx_fc_en = cfg.rx_en;
    assign st_tx_fc_en = cfg.tx_en;
    assign st_kick     = cfg.kick;

    // R10: each jam request answers a frame start with transmit enable set
    a_r10_jam_after_sof: assert property (@(posedge clk) disable iff (rst)
        jam_strobe |-> $past(rx_valid && rx_sof && cfg.tx_en));

    // R11: no jam request is made in full duplex
    a_r11_no_jam_fd: assert property (@(posedge clk) disable iff (rst)
        jam_strobe |-> $past(!full_duplex));

endmodule

// File: tb/tb_mac_pause_ctrl.sv
`timescale 1ns/1ps
module tb_mac_pause_ctrl;

    localparam logic [47:0] SA = 48'h021A2B3C4D5E;
    localparam int          FB = 60;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        full_duplex = 1'b1;
    logic        cfg_we = 1'b0, cfg_rx_fc_en = 1'b0, cfg_tx_fc_en = 1'b0, cfg_kick = 1'b0;
    logic [15:0] cfg_tx_quanta = '0;
    logic        st_rx_fc_en, st_tx_fc_en, st_kick;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        quanta_tick = 1'b0;
    logic        tx_hold, jam_strobe, ctl_valid, ctl_last;
    logic [7:0]  ctl_data;
    logic        ctl_ready = 1'b0;

    int total = 0;
    int bad   = 0;
    logic [7:0] fr [0:63];
    logic [7:0] got [0:63];

    always #2 clk = ~clk;

    mac_pause_ctrl #(.FRAME_BYTES(FB), .STATION_ADDR(SA)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    function automatic logic [7:0] exp_ctl(input int i, input logic [15:0] q);
        logic [7:0] hdr [0:5];
        hdr = '{8'h01, 8'h80, 8'hC2, 8'h00, 8'h00, 8'h01};
        if (i < 6)  return hdr[i];
        if (i < 12) return SA[8*(11-i) +: 8];
        case (i)
            12: return 8'h88;
            13: return 8'h08;
            14: return 8'h00;
            15: return 8'h01;
            16: return q[15:8];
            17: return q[7:0];
            default: return 8'h00;
        endcase
    endfunction

    task automatic fill_pause(input logic [15:0] q);
        for (int i = 0; i < 64; i++) fr[i] = 8'h00;
        fr[0] = 8'h01; fr[1] = 8'h80; fr[2] = 8'hC2; fr[3] = 8'h00; fr[4] = 8'h00; fr[5] = 8'h01;
        for (int i = 6; i < 12; i++) fr[i] = 8'h30 + 8'(i);
        fr[12] = 8'h88; fr[13] = 8'h08; fr[14] = 8'h00; fr[15] = 8'h01;
        fr[16] = q[15:8]; fr[17] = q[7:0];
    endtask

    task automatic cfg_write(input bit rxe, input bit txe, input bit k, input logic [15:0] q);
        @(negedge clk);
        cfg_we = 1'b1; cfg_rx_fc_en = rxe; cfg_tx_fc_en = txe; cfg_kick = k; cfg_tx_quanta = q;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send_rx(input int len);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1; rx_data = fr[i]; rx_sof = (i == 0); rx_eof = (i == len - 1);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk); quanta_tick = 1'b1;
        @(negedge clk); quanta_tick = 1'b0;
    endtask

    task automatic t_reset();
        chk(st_rx_fc_en == 0 && st_tx_fc_en == 0 && st_kick == 0, "R1", "readback bits",
            {st_rx_fc_en, st_tx_fc_en, st_kick}, 0);
        chk(tx_hold == 0 && jam_strobe == 0 && ctl_valid == 0, "R1", "outputs idle",
            {tx_hold, jam_strobe, ctl_valid}, 0);
    endtask

    task automatic t_cfg_write();
        cfg_write(1, 1, 0, 16'h1234);
        chk(st_rx_fc_en == 1 && st_tx_fc_en == 1 && st_kick == 0, "R2", "readback after write",
            {st_rx_fc_en, st_tx_fc_en, st_kick}, 3'b110);
    endtask

    // Sends one control frame; optionally stalls and tries a write mid-frame.
    task automatic t_ctl_frame(input logic [15:0] q, input bit stall);
        int n = 0;
        int cyc = 0;
        bit fin = 0;
        bit busy_ok = 1;
        cfg_write(1, 1, 1, q);
        chk(st_kick == 1, "R4", "busy set after request", st_kick, 1);
        while (!fin && cyc < 400) begin
            ctl_ready = stall ? ((cyc % 3) != 1) : 1'b1;
            if (stall && cyc == 2) begin
                cfg_we = 1'b1; cfg_rx_fc_en = 0; cfg_tx_fc_en = 0; cfg_kick = 0;
                cfg_tx_quanta = 16'hFFFF;
            end else begin
                cfg_we = 1'b0;
            end
            if (!st_kick) busy_ok = 0;
            if (ctl_valid && ctl_ready) begin
                if (n < 64) got[n] = ctl_data;
                if (ctl_last) fin = 1;
                n++;
            end
            @(negedge clk);
            cyc++;
        end
        cfg_we = 1'b0; ctl_ready = 1'b0;
        chk(n == FB, "R3", "frame length", n, FB);
        chk(busy_ok, "R4", "busy held during frame", busy_ok, 1);
        chk(st_kick == 0 && ctl_valid == 0, "R4", "busy cleared after last byte",
            {st_kick, ctl_valid}, 0);
        for (int i = 0; i < FB && i < 64; i++)
            chk(got[i] == exp_ctl(i, q), "R3", $sformatf("byte %0d", i), got[i], exp_ctl(i, q));
        if (stall)
            chk(st_rx_fc_en == 1 && st_tx_fc_en == 1, "R5", "write during frame ignored",
                {st_rx_fc_en, st_tx_fc_en}, 2'b11);
    endtask

    task automatic t_kick_no_tx();
        int seen = 0;
        cfg_write(1, 0, 1, 16'h0077);
        chk(st_kick == 0, "R6", "kick refused without tx enable", st_kick, 0);
        for (int i = 0; i < 8; i++) begin
            if (ctl_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R6", "no frame emitted", seen, 0);
    endtask

    task automatic t_rx_pause();
        cfg_write(1, 0, 0, 16'h0000);
        fill_pause(16'd3);
        send_rx(60);
        chk(tx_hold == 0, "R7", "hold not yet raised", tx_hold, 0);
        @(negedge clk);
        chk(tx_hold == 1, "R7", "hold raised by pause frame", tx_hold, 1);
        tick(); tick();
        chk(tx_hold == 1, "R8", "hold after 2 of 3 quanta", tx_hold, 1);
        tick();
        chk(tx_hold == 0, "R8", "hold released after 3 quanta", tx_hold, 0);
    endtask

    task automatic t_reload();
        fill_pause(16'd5);
        send_rx(60); @(negedge clk);
        tick(); tick();
        fill_pause(16'd2);
        send_rx(60); @(negedge clk);
        tick();
        chk(tx_hold == 1, "R8", "reloaded count still running", tx_hold, 1);
        tick();
        chk(tx_hold == 0, "R8", "reloaded count expired", tx_hold, 0);
        fill_pause(16'd4);
        send_rx(60); @(negedge clk);
        chk(tx_hold == 1, "R8", "hold before zero frame", tx_hold, 1);
        fill_pause(16'd0);
        send_rx(60); @(negedge clk);
        chk(tx_hold == 0, "R8", "zero pause time releases", tx_hold, 0);
    endtask

    task automatic t_mismatch();
        for (int k = 0; k < 4; k++) begin
            int len = 60;
            fill_pause(16'd9);
            case (k)
                0: fr[5]  = 8'h02;
                1: fr[13] = 8'h09;
                2: fr[15] = 8'h02;
                default: len = 17;
            endcase
            send_rx(len); @(negedge clk); @(negedge clk);
            chk(tx_hold == 0, "R9", $sformatf("non-matching frame %0d ignored", k), tx_hold, 0);
        end
        fill_pause(16'd1);
        send_rx(18); @(negedge clk);
        chk(tx_hold == 1, "R9", "minimal 18-byte frame accepted", tx_hold, 1);
        tick();
    endtask

    task automatic t_rx_disable();
        fill_pause(16'd10);
        send_rx(60); @(negedge clk);
        chk(tx_hold == 1, "R7", "hold before disable", tx_hold, 1);
        cfg_write(0, 0, 0, 16'h0000);
        @(negedge clk);
        chk(tx_hold == 0, "R7", "disable releases hold", tx_hold, 0);
        fill_pause(16'd10);
        send_rx(60); @(negedge clk); @(negedge clk);
        chk(tx_hold == 0, "R7", "frame ignored when disabled", tx_hold, 0);
    endtask

    task automatic jam_probe(input bit exp, input string req, input string what);
        @(negedge clk);
        rx_valid = 1'b1; rx_sof = 1'b1; rx_data = 8'h55;
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0;
        chk(jam_strobe == exp, req, what, jam_strobe, exp);
        @(negedge clk);
        chk(jam_strobe == 0, req, {what, " single cycle"}, jam_strobe, 0);
    endtask

    task automatic t_half_duplex();
        int seen = 0;
        @(negedge clk); full_duplex = 1'b0;
        cfg_write(0, 0, 1, 16'h0000);
        chk(st_kick == 1, "R10", "level held in half duplex", st_kick, 1);
        jam_probe(0, "R10", "no jam without tx enable");
        cfg_write(0, 1, 1, 16'h0000);
        for (int i = 0; i < 6; i++) begin
            if (ctl_valid) seen++;
            @(negedge clk);
        end
        chk(seen == 0 && st_kick == 1, "R10", "no frame, bit still held", seen, 0);
        jam_probe(1, "R10", "jam on new frame");
        jam_probe(1, "R10", "jam on next frame");
    endtask

    task automatic t_duplex_switch();
        @(negedge clk); full_duplex = 1'b1;
        @(negedge clk);
        chk(st_kick == 0, "R11", "bit cleared on full duplex", st_kick, 0);
        jam_probe(0, "R11", "no jam in full duplex");
        @(negedge clk); full_duplex = 1'b0;
        @(negedge clk);
        jam_probe(0, "R11", "back pressure stays off");
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog: actual=expired expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_cfg_write();
        t_ctl_frame(16'h1234, 1);
        t_ctl_frame(16'h00A5, 0);
        t_kick_no_tx();
        t_rx_pause();
        t_reload();
        t_mismatch();
        t_rx_disable();
        t_half_duplex();
        t_duplex_switch();
        finish_run();
    end

endmodule